// File: doc/BRIEF.md
# Asynchronous FSK Byte Receiver

This block rebuilds bytes from the bit stream that an FSK demodulator produces. The serial line and a carrier-level-good flag are both asynchronous, so each passes through a two-flop synchronizer. The line is then sampled on an oversampling tick that runs at sixteen times the bit rate. The tick comes from a divider that is set by the system clock frequency and the baud parameters. A low level on the line starts a frame. The low level must still be present half a bit later. After that, eight data bits arrive least significant bit first, and each is sampled at its centre. A stop bit ends the frame.

A finished byte leaves on a valid/ready output. `out_valid` also serves as the interrupt request, and `out_ready` is the host's read strobe. A byte is taken in any cycle where both are high. The byte and `out_valid` hold steady until that happens. The host cannot apply back-pressure to the serial line. If a new byte completes while the previous one is still pending, the new byte replaces it and the overrun flag is set.

Framing and overrun errors each have a sticky status bit. A pulse on `status_rd` clears both bits. When the carrier flag is low, the receiver ignores the line, and a status bit shows that data is being rejected.

Top module: `fsk_byte_rx`

## Requirements
- R1: A frame is a low start bit, then eight data bits with bit 0 first, then a high stop bit. The bits travel in this order. A good frame places its byte on `out_data` and sets `out_valid`.
- R2: A low level on the line that has ended by the middle of the start bit is a failed start. It delivers no byte and sets status bit 2, the framing flag.
- R3: A low stop bit sets status bit 2, and the byte in that frame is thrown away. `out_valid` and `out_data` keep their previous values.
- R4: A byte can complete while `out_valid` is high and `out_ready` is low in that cycle. In that case status bit 3, the overrun flag, is set, and `out_data` takes the new byte.
- R5: `out_valid` rises once the stop bit has been sampled. Until a handshake, `out_valid` stays high and `out_data` stays unchanged. `out_valid` is low in the cycle after `out_valid` and `out_ready` are both high, unless a new byte completed in that same cycle.
- R6: Status bits 2 and 3 stay set until `status_rd` is pulsed, and the pulse clears them. If a new error arrives in the same cycle as the pulse, the flag stays set.
- R7: While `carrier_ok` is low, status bit 4 reads 1. No byte is delivered and no error flag is raised. If the carrier drops partway through a frame, that frame is abandoned.
- R8: After reset, `out_valid` is 0 and status bits 2 and 3 are 0. Status bits 0, 1, 5, 6 and 7 always read 0.
- R9: One bit lasts 16 oversampling ticks. The tick period is CLK_HZ / (BAUD * 16) clock cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rx_in | input | 1 | Demodulated serial line, asynchronous |
| carrier_ok | input | 1 | Carrier level above reference, asynchronous |
| out_data | output | 8 | Received byte |
| out_valid | output | 1 | Byte pending; also the interrupt request |
| out_ready | input | 1 | Host read strobe; a byte is taken when both this and `out_valid` are high |
| status_rd | input | 1 | Status read pulse; clears the error flags |
| status_o | output | 8 | Bit 2 framing error, bit 3 overrun, bit 4 carrier rejected |

## Verification
Assertions check the following on every cycle:
- the output byte holds steady while it waits for a handshake;
- `out_valid` drops after a handshake;
- the overrun flag is set whenever an unread byte is overwritten;
- the error flags stay set until a status read;
- the frame engine never reports a byte and a framing error together;
- the frame engine returns to idle when the carrier goes away.

Other behaviour can only be shown by the bench's scenarios: the bits being reassembled in the right order, a short start glitch being rejected at mid-bit, a bad stop bit being caught, and frames being ignored while the carrier is low or after it drops partway through a frame. The bench drives the serial line at the configured bit timing.

// File: rtl/fsk_rx_pkg.sv
package fsk_rx_pkg;
  localparam int OVS      = 16;  // ticks per bit (R9)
  localparam int ST_FRM   = 2;   // framing flag position
  localparam int ST_OVR   = 3;   // overrun flag position
  localparam int ST_NOCAR = 4;   // carrier rejected position
  localparam int ST_W     = 8;

  typedef enum logic [1:0] {
    RX_IDLE,
    RX_START,
    RX_DATA,
    RX_STOP
  } rx_state_e;
endpackage

// File: rtl/fsk_sync2.sv
module fsk_sync2 #(
  parameter int         W       = 1,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] meta;

  for (genvar i = 0; i < W; i++) begin : g_bit
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        meta[i] <= RST_VAL[i];
        q[i]    <= RST_VAL[i];
      end else begin
        meta[i] <= d[i];
        q[i]    <= meta[i];
      end
    end
  end
endmodule

// File: rtl/fsk_tick_gen.sv
module fsk_tick_gen #(
  parameter int DIV = 4
) (
  input  logic clk,
  input  logic rst_n,
  output logic tick
);
  localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [CW-1:0] LAST = CW'(DIV - 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt  <= '0;
      tick <= 1'b0;
    end else if (cnt == LAST) begin
      cnt  <= '0;
      tick <= 1'b1;
    end else begin
      cnt  <= cnt + 1'b1;
      tick <= 1'b0;
    end
  end
endmodule

// File: rtl/fsk_rx_frame.sv
module fsk_rx_frame
  import fsk_rx_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick,
  input  logic          rx,
  input  logic          car_ok,
  output logic          byte_done,
  output logic [DW-1:0] byte_q,
  output logic          frame_err
);
  localparam int CNT_W = $clog2(OVS);
  localparam int BIX_W = $clog2(DW) + 1;
  localparam logic [CNT_W-1:0] HALF_LAST = CNT_W'(OVS / 2 - 1);
  localparam logic [CNT_W-1:0] FULL_LAST = CNT_W'(OVS - 1);
  localparam logic [BIX_W-1:0] BIT_LAST  = BIX_W'(DW - 1);

  rx_state_e        state;
  logic [CNT_W-1:0] ocnt;
  logic [BIX_W-1:0] bidx;
  logic [DW-1:0]    shreg;

  assign byte_q = shreg;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= RX_IDLE;
      ocnt      <= '0;
      bidx      <= '0;
      shreg     <= '0;
      byte_done <= 1'b0;
      frame_err <= 1'b0;
    end else begin
      byte_done <= 1'b0;
      frame_err <= 1'b0;
      if (!car_ok) begin
        state <= RX_IDLE;                 // R7: reject while carrier is low
      end else if (tick) begin
        case (state)
          RX_IDLE: begin
            if (!rx) begin
              state <= RX_START;
              ocnt  <= '0;
            end
          end
          RX_START: begin
            if (ocnt == HALF_LAST) begin  // R2: mid-bit check of start
              ocnt <= '0;
              if (!rx) begin
                state <= RX_DATA;
                bidx  <= '0;
              end else begin
                state     <= RX_IDLE;
                frame_err <= 1'b1;
              end
            end else begin
              ocnt <= ocnt + 1'b1;
            end
          end
          RX_DATA: begin
            if (ocnt == FULL_LAST) begin  // R1: bit centre, LSB first
              ocnt  <= '0;
              shreg <= {rx, shreg[DW-1:1]};
              if (bidx == BIT_LAST) state <= RX_STOP;
              else                  bidx  <= bidx + 1'b1;
            end else begin
              ocnt <= ocnt + 1'b1;
            end
          end
          RX_STOP: begin
            if (ocnt == FULL_LAST) begin  // R3: stop level check
              ocnt  <= '0;
              state <= RX_IDLE;
              if (rx) byte_done <= 1'b1;
              else    frame_err <= 1'b1;
            end else begin
              ocnt <= ocnt + 1'b1;
            end
          end
          default: state <= RX_IDLE;
        endcase
      end
    end
  end

  assert_carrier_abort_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !car_ok |=> (state == RX_IDLE) && !byte_done && !frame_err);

  assert_one_outcome_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({byte_done, frame_err}));
endmodule

// File: rtl/fsk_byte_rx.sv
module fsk_byte_rx
  import fsk_rx_pkg::*;
#(
  parameter int CLK_HZ = 3_686_400,
  parameter int BAUD   = 1200,
  parameter int DW     = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            rx_in,
  input  logic            carrier_ok,
  output logic [DW-1:0]   out_data,
  output logic            out_valid,
  input  logic            out_ready,
  input  logic            status_rd,
  output logic [ST_W-1:0] status_o
);
  localparam int DIV_RAW = CLK_HZ / (BAUD * OVS);   // R9
  localparam int DIV     = (DIV_RAW < 1) ? 1 : DIV_RAW;

  logic          rx_s, car_s, tick;
  logic          byte_done, frame_err;
  logic [DW-1:0] byte_q;
  logic          frm_f, ovr_f;

  // line idles high, carrier assumed absent until seen
  fsk_sync2 #(.W(2), .RST_VAL(2'b01)) u_sync (
    .clk (clk), .rst_n (rst_n),
    .d   ({carrier_ok, rx_in}),
    .q   ({car_s, rx_s})
  );

  fsk_tick_gen #(.DIV(DIV)) u_tick (
    .clk (clk), .rst_n (rst_n), .tick (tick)
  );

  fsk_rx_frame #(.DW(DW)) u_frame (
    .clk (clk), .rst_n (rst_n), .tick (tick), .rx (rx_s), .car_ok (car_s),
    .byte_done (byte_done), .byte_q (byte_q), .frame_err (frame_err)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_data  <= '0;
      out_valid <= 1'b0;
      frm_f     <= 1'b0;
      ovr_f     <= 1'b0;
    end else begin
      if (byte_done) begin
        out_data  <= byte_q;
        out_valid <= 1'b1;
      end else if (out_valid && out_ready) begin
        out_valid <= 1'b0;
      end
      if (byte_done && out_valid && !out_ready) ovr_f <= 1'b1;
      else if (status_rd)                      ovr_f <= 1'b0;
      if (frame_err)      frm_f <= 1'b1;
      else if (status_rd) frm_f <= 1'b0;
    end
  end

  always_comb begin
    status_o           = '0;
    status_o[ST_FRM]   = frm_f;
    status_o[ST_OVR]   = ovr_f;
    status_o[ST_NOCAR] = ~car_s;
  end

  assert_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready && !byte_done |=> out_valid && $stable(out_data));

  assert_release_R5: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_ready && !byte_done |=> !out_valid);

  assert_overrun_R4: assert property (@(posedge clk) disable iff (!rst_n)
    byte_done && out_valid && !out_ready |=> status_o[ST_OVR]);

  assert_sticky_frm_R6: assert property (@(posedge clk) disable iff (!rst_n)
    status_o[ST_FRM] && !status_rd |=> status_o[ST_FRM]);

  assert_sticky_ovr_R6: assert property (@(posedge clk) disable iff (!rst_n)
    status_o[ST_OVR] && !status_rd |=> status_o[ST_OVR]);
endmodule

// File: tb/fsk_byte_rx_test.sv
module fsk_byte_rx_test;
  localparam int BAUD   = 1200;
  localparam int CLK_HZ = BAUD * 16 * 4;   // 4 clocks per tick
  localparam int BITC   = 16 * 4;          // clocks per bit (R9)

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       rx_in = 1'b1;
  logic       carrier_ok = 1'b1;
  logic [7:0] out_data;
  logic       out_valid;
  logic       out_ready = 1'b0;
  logic       status_rd = 1'b0;
  logic [7:0] status_o;

  int checks = 0;
  int errors = 0;

  logic       e_valid = 1'b0;
  logic [7:0] e_data  = 8'h00;
  logic       e_frm   = 1'b0;
  logic       e_ovr   = 1'b0;

  always #2.5 clk = ~clk;

  fsk_byte_rx #(.CLK_HZ(CLK_HZ), .BAUD(BAUD), .DW(8)) uut (
    .clk (clk), .rst_n (rst_n), .rx_in (rx_in), .carrier_ok (carrier_ok),
    .out_data (out_data), .out_valid (out_valid), .out_ready (out_ready),
    .status_rd (status_rd), .status_o (status_o)
  );

  function automatic logic [7:0] exp_status(logic frm, logic ovr, logic nocar);
    logic [7:0] s;
    s = 8'h00;
    s[2] = frm;
    s[3] = ovr;
    s[4] = nocar;
    return s;
  endfunction

  function automatic logic frame_level(logic [7:0] b, int idx, logic stop_lvl);
    if (idx == 0) return 1'b0;
    if (idx == 9) return stop_lvl;
    return b[idx-1];
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wait_clk(int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  // drop_at: bit index at which carrier is removed, -1 for none
  task automatic send_frame(logic [7:0] b, logic stop_lvl, int drop_at);
    for (int i = 0; i < 10; i++) begin
      if (i == drop_at) carrier_ok = 1'b0;
      rx_in = frame_level(b, i, stop_lvl);
      wait_clk(BITC);
    end
    rx_in = 1'b1;
    wait_clk(BITC);
  endtask

  task automatic check_all(string req);
    check({req, " data"},   {31'd0, out_valid}, {31'd0, e_valid});
    if (e_valid) check({req, " byte"}, {24'd0, out_data}, {24'd0, e_data});
    check({req, " status"}, {24'd0, status_o}, {24'd0, exp_status(e_frm, e_ovr, 1'b0)});
  endtask

  task automatic host_read;
    out_ready = 1'b1;
    wait_clk(1);
    out_ready = 1'b0;
    e_valid = 1'b0;
    wait_clk(1);
  endtask

  task automatic status_read;
    status_rd = 1'b1;
    wait_clk(1);
    status_rd = 1'b0;
    e_frm = 1'b0;
    e_ovr = 1'b0;
    wait_clk(1);
  endtask

  task automatic good_byte(logic [7:0] b);
    send_frame(b, 1'b1, -1);
    if (e_valid) e_ovr = 1'b1;
    e_valid = 1'b1;
    e_data  = b;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'h1F5C));
    wait_clk(5);
    rst_n = 1'b1;
    wait_clk(5);
    // R8: reset state
    check("R8 valid", {31'd0, out_valid}, 32'd0);
    check("R8 status", {24'd0, status_o}, 32'h0);

    // R1 / R5: single byte, then handshake
    good_byte(8'hA5);
    check_all("R1");
    wait_clk(20);
    check("R5 hold", {24'd0, out_data}, 32'hA5);
    check("R5 hold valid", {31'd0, out_valid}, 32'd1);
    host_read();
    check("R5 release", {31'd0, out_valid}, 32'd0);

    // R4: two bytes without read
    good_byte(8'h3C);
    good_byte(8'hC1);
    check_all("R4");
    // R6: flag survives another byte, cleared by status read
    host_read();
    good_byte(8'h80);
    check_all("R6 sticky");
    status_read();
    check_all("R6 clear");
    host_read();

    // R3: low stop bit
    send_frame(8'h5A, 1'b0, -1);
    e_frm = 1'b1;
    check_all("R3");
    status_read();

    // R2: glitch shorter than half a bit
    rx_in = 1'b0;
    wait_clk(BITC / 4);
    rx_in = 1'b1;
    wait_clk(2 * BITC);
    e_frm = 1'b1;
    check_all("R2");
    status_read();
    check_all("R2 cleared");

    // R7: carrier absent, frame ignored
    carrier_ok = 1'b0;
    wait_clk(5);
    check("R7 bit4", {24'd0, status_o}, {24'd0, exp_status(1'b0, 1'b0, 1'b1)});
    send_frame(8'h0F, 1'b1, -1);
    check("R7 ignored valid", {31'd0, out_valid}, 32'd0);
    check("R7 ignored status", {24'd0, status_o}, {24'd0, exp_status(1'b0, 1'b0, 1'b1)});
    carrier_ok = 1'b1;
    wait_clk(5);
    // R7: carrier lost mid-frame
    send_frame(8'hF0, 1'b1, 4);
    check("R7 abort valid", {31'd0, out_valid}, 32'd0);
    carrier_ok = 1'b1;
    wait_clk(5);
    check_all("R7 recovered");

    // R9 / R1 / R4 / R5 / R6: random bytes with random host actions
    for (int n = 0; n < 24; n++) begin
      logic [7:0] b;
      b = 8'($urandom);
      if (n == 0) b = 8'h00;
      if (n == 1) b = 8'hFF;
      good_byte(b);
      check_all("R9 random");
      if ($urandom_range(0, 1) == 1) host_read();
      if ($urandom_range(0, 3) == 0) status_read();
      check_all("R5 random");
    end

    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule